// File: doc/BRIEF.md
# Dual 8-bit PWM Timer Pair

The block holds two independent pulse-width channels. Each channel has its own 8-bit counter, a prescaler, a period value, a duty value, a run bit and a polarity bit, and it drives one output pin. A channel's counter advances once every (prescale + 1) clock cycles while its run bit is set. The counter clears to 00h on the step that follows a match with the period value. The pin leaves its idle level on each 00h-to-01h step of the counter. It goes back to idle on the step that follows a match with the duty value. The result is a waveform with a period of (period + 1) × (prescale + 1) clocks.

Software reaches every field through a single-cycle synchronous register bus with a combinational read port. Period and duty writes go into a buffer. While either channel runs, the buffered value reaches the comparators only at that channel's period match. When both channels are stopped, it reaches them at once. Counters can be preset only while both channels are stopped. A preset above the period makes the counter run up through FFh and wrap to 00h, which allows the two outputs to be placed out of phase.

Top module: `dual_pwm8`

## Requirements
- R1: After reset, every register reads 00h and both pins are low.
- R2: While a channel's run bit is set, its counter advances on every (prescale+1)-th clock cycle. Its prescaler count starts from zero.
- R3: A counter equal to the active period value becomes 00h on its next advance. Otherwise an advance adds one, and FFh wraps to 00h.
- R4: On an advance from 00h to 01h, the channel's pin becomes active (not idle) if the active duty value is nonzero.
- R5: On the advance that follows a counter equal to the active duty value, the pin returns to idle. This applies only when the duty value is not greater than the period value.
- R6: A duty value greater than the period value keeps the pin active for every cycle once it is reached. A duty value of 00h keeps the pin idle.
- R7: While either channel runs, period and duty writes reach the comparators only at that channel's period-match clear. While both channels are stopped, they take effect one cycle after the write.
- R8: Register map, with reads returning the last value written. 0 = control: bit0 run ch0, bit1 run ch1, bit2 polarity ch0, bit3 polarity ch1. 1/2 = prescale ch0/ch1. 3/4 = period ch0/ch1. 5/6 = duty ch0/ch1. 7/8 = counter ch0/ch1 (reads return the live count).
- R9: A counter write takes effect only when both run bits are clear. Otherwise it is ignored.
- R10: A counter preset above the period counts through FFh, wraps to 00h and then runs normal periods.
- R11: A counter preset forces the pin to idle, and the pin stays idle until that counter's first 00h-to-01h advance.
- R12: Clearing a run bit freezes that channel's counter and pin. The channel's prescaler count returns to zero.
- R13: The idle level equals the polarity bit, and the pin equals the active state XOR polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for addr (combinational) |
| pwmOut | output | 2 | PWM pins, bit n is channel n |

## Verification
The in-RTL properties assume a period value of at least one whenever a channel runs with a nonzero duty value. With a period of zero, the counter never takes the 00h-to-01h step. They also assume that bus writes are single-cycle strobes against a registered run state, so that a counter write and an advance never meet. The stimulus uses periods of 4 to 9, writes one register per strobe, and changes run bits only through complete control writes. Every preset and prescale change is made with both channels stopped, apart from the deliberate ignored-write case.

// File: rtl/dual_pwm8_pkg.sv
package dual_pwm8_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 4;
  localparam int NUM_CH = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 4'd0;
  localparam logic [ADDR_W-1:0] ADDR_PRSC = 4'd1;
  localparam logic [ADDR_W-1:0] ADDR_PER  = 4'd3;
  localparam logic [ADDR_W-1:0] ADDR_DUTY = 4'd5;
  localparam logic [ADDR_W-1:0] ADDR_CNT  = 4'd7;

  typedef struct packed {
    logic              run;
    logic              anyRun;
    logic              wrPer;
    logic              wrDuty;
    logic              wrCnt;
    logic [DATA_W-1:0] data;
    logic [DATA_W-1:0] prscLim;
  } chanCmd_t;
endpackage

// File: rtl/dual_pwm8_chan.sv
module dual_pwm8_chan
  import dual_pwm8_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  chanCmd_t          cmd,
  output logic [DATA_W-1:0] cntQ,
  output logic [DATA_W-1:0] perBuf,
  output logic [DATA_W-1:0] dutyBuf,
  output logic              actQ
);
  logic [DATA_W-1:0] prscQ;
  logic [DATA_W-1:0] perAct;
  logic [DATA_W-1:0] dutyAct;
  logic              tick;
  logic              perHit;
  logic              stepUp;
  logic              dutyHit;
  logic [DATA_W-1:0] nextCnt;

  always_comb begin
    tick    = cmd.run && (prscQ >= cmd.prscLim);
    perHit  = (cntQ == perAct);
    nextCnt = perHit ? '0 : cntQ + 1'b1;
    stepUp  = (cntQ == '0) && (nextCnt == DATA_W'(1));
    dutyHit = (cntQ == dutyAct) && (dutyAct <= perAct);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prscQ   <= '0;
      cntQ    <= '0;
      perBuf  <= '0;
      dutyBuf <= '0;
      perAct  <= '0;
      dutyAct <= '0;
      actQ    <= 1'b0;
    end else begin
      if (!cmd.run || tick) prscQ <= '0;
      else                  prscQ <= prscQ + 1'b1;

      if (tick) begin
        cntQ <= nextCnt;
        if (stepUp)       actQ <= (dutyAct != '0);
        else if (dutyHit) actQ <= 1'b0;
        if (perHit) begin
          perAct  <= perBuf;
          dutyAct <= dutyBuf;
        end
      end else if (cmd.wrCnt && !cmd.anyRun) begin
        cntQ <= cmd.data;
        actQ <= 1'b0;
      end

      if (!cmd.anyRun) begin
        perAct  <= perBuf;
        dutyAct <= dutyBuf;
      end
      if (cmd.wrPer)  perBuf  <= cmd.data;
      if (cmd.wrDuty) dutyBuf <= cmd.data;
    end
  end

  // R3: a match with the period clears the counter on the advance
  a_r3_period_clear: assert property (@(posedge clk) disable iff (!rstN)
    (tick && cntQ == perAct) |=> (cntQ == '0));

  // R7: compare values do not move while running, except at a period clear
  a_r7_shadow_hold: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.anyRun && !(tick && perHit)) |=> ($stable(perAct) && $stable(dutyAct)));

  // R9: a counter write while running leaves the count alone
  a_r9_cnt_protect: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.wrCnt && cmd.anyRun && !tick) |=> $stable(cntQ));

  // R6: with a zero duty value the channel never becomes active
  a_r6_zero_duty: assert property (@(posedge clk) disable iff (!rstN)
    (dutyAct == '0 && !actQ) |=> !actQ);

  // R4: the active state only starts on a 00h-to-01h advance
  a_r4_rise_at_step: assert property (@(posedge clk) disable iff (!rstN)
    $rose(actQ) |-> ($past(tick) && $past(cntQ) == '0));
endmodule

// File: rtl/dual_pwm8_ctrl.sv
module dual_pwm8_ctrl
  import dual_pwm8_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            wrEn,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [DATA_W-1:0]               wrData,
  input  logic [NUM_CH-1:0][DATA_W-1:0]   cntIn,
  input  logic [NUM_CH-1:0][DATA_W-1:0]   perIn,
  input  logic [NUM_CH-1:0][DATA_W-1:0]   dutyIn,
  output chanCmd_t [NUM_CH-1:0]           cmd,
  output logic [NUM_CH-1:0]               polQ,
  output logic [DATA_W-1:0]               rdData
);
  logic [NUM_CH-1:0]             runQ;
  logic [NUM_CH-1:0][DATA_W-1:0] prscQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ  <= '0;
      polQ  <= '0;
      prscQ <= '0;
    end else if (wrEn) begin
      if (addr == ADDR_CTRL) begin
        runQ <= wrData[NUM_CH-1:0];
        polQ <= wrData[2*NUM_CH-1:NUM_CH];
      end
      for (int c = 0; c < NUM_CH; c++)
        if (addr == ADDR_PRSC + ADDR_W'(c)) prscQ[c] <= wrData;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_cmd
    always_comb begin
      cmd[c].run     = runQ[c];
      cmd[c].anyRun  = |runQ;
      cmd[c].wrPer   = wrEn && (addr == ADDR_PER  + ADDR_W'(c));
      cmd[c].wrDuty  = wrEn && (addr == ADDR_DUTY + ADDR_W'(c));
      cmd[c].wrCnt   = wrEn && (addr == ADDR_CNT  + ADDR_W'(c));
      cmd[c].data    = wrData;
      cmd[c].prscLim = prscQ[c];
    end
  end

  always_comb begin
    rdData = '0;
    if (addr == ADDR_CTRL) rdData = DATA_W'({polQ, runQ});
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr == ADDR_PRSC + ADDR_W'(c)) rdData = prscQ[c];
      if (addr == ADDR_PER  + ADDR_W'(c)) rdData = perIn[c];
      if (addr == ADDR_DUTY + ADDR_W'(c)) rdData = dutyIn[c];
      if (addr == ADDR_CNT  + ADDR_W'(c)) rdData = cntIn[c];
    end
  end
endmodule

// File: rtl/dual_pwm8.sv
module dual_pwm8
  import dual_pwm8_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [NUM_CH-1:0] pwmOut
);
  chanCmd_t [NUM_CH-1:0]         cmd;
  logic [NUM_CH-1:0]             polQ;
  logic [NUM_CH-1:0]             actQ;
  logic [NUM_CH-1:0][DATA_W-1:0] cntQ;
  logic [NUM_CH-1:0][DATA_W-1:0] perBuf;
  logic [NUM_CH-1:0][DATA_W-1:0] dutyBuf;

  dual_pwm8_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .cntIn(cntQ), .perIn(perBuf), .dutyIn(dutyBuf),
    .cmd(cmd), .polQ(polQ), .rdData(rdData)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dual_pwm8_chan u_chan (
      .clk(clk), .rstN(rstN), .cmd(cmd[c]),
      .cntQ(cntQ[c]), .perBuf(perBuf[c]), .dutyBuf(dutyBuf[c]), .actQ(actQ[c])
    );
    assign pwmOut[c] = actQ[c] ^ polQ[c];
  end
endmodule

// File: tb/dual_pwm8_bench.sv
module dual_pwm8_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [3:0] addr = 4'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic [1:0] pwmOut;

  dual_pwm8 u_dual_pwm8 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .pwmOut(pwmOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;
  string curReq = "R1";

  // behavioural reference model
  int mRun[2], mPol[2], mPs[2], mPc[2], mCnt[2];
  int mPerB[2], mPerA[2], mDutyB[2], mDutyA[2], mAct[2];

  task automatic modelReset();
    for (int c = 0; c < 2; c++) begin
      mRun[c] = 0; mPol[c] = 0; mPs[c] = 0; mPc[c] = 0; mCnt[c] = 0;
      mPerB[c] = 0; mPerA[c] = 0; mDutyB[c] = 0; mDutyA[c] = 0; mAct[c] = 0;
    end
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) modelReset();
    else begin
      int anyRun;
      int a;
      int d;
      anyRun = (mRun[0] != 0 || mRun[1] != 0) ? 1 : 0;
      a = int'(addr);
      d = int'(wrData);
      for (int c = 0; c < 2; c++) begin
        bit tk;
        bit ld;
        int nc;
        tk = (mRun[c] != 0) && (mPc[c] >= mPs[c]);
        ld = 0;
        mPc[c] = (mRun[c] == 0 || tk) ? 0 : mPc[c] + 1;
        if (tk) begin
          if (mCnt[c] == mPerA[c]) begin nc = 0; ld = 1; end
          else nc = (mCnt[c] + 1) % 256;
          if (mCnt[c] == 0 && nc == 1) mAct[c] = (mDutyA[c] != 0) ? 1 : 0;
          else if (mCnt[c] == mDutyA[c] && mDutyA[c] <= mPerA[c]) mAct[c] = 0;
          mCnt[c] = nc;
        end else if (wrEn && a == 7 + c && anyRun == 0) begin
          mCnt[c] = d; mAct[c] = 0;
        end
        if (ld || anyRun == 0) begin mPerA[c] = mPerB[c]; mDutyA[c] = mDutyB[c]; end
        if (wrEn && a == 3 + c) mPerB[c] = d;
        if (wrEn && a == 5 + c) mDutyB[c] = d;
        if (wrEn && a == 1 + c) mPs[c] = d;
      end
      if (wrEn && a == 0) begin
        mRun[0] = d & 1; mRun[1] = (d >> 1) & 1;
        mPol[0] = (d >> 2) & 1; mPol[1] = (d >> 3) & 1;
      end
    end
  end

  function automatic int mRead(int a);
    case (a)
      0: return mRun[0] | (mRun[1] << 1) | (mPol[0] << 2) | (mPol[1] << 3);
      1, 2: return mPs[a-1];
      3, 4: return mPerB[a-3];
      5, 6: return mDutyB[a-5];
      7, 8: return mCnt[a-7];
      default: return 0;
    endcase
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // pin comparison on every clock, away from the edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      for (int c = 0; c < 2; c++) begin
        int e;
        e = mAct[c] ^ mPol[c];
        chk(int'(pwmOut[c]) == e, curReq, int'(pwmOut[c]), e);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    wrEn = 1'b1; addr = 4'(a); wrData = 8'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(int a, string req);
    int e;
    @(negedge clk);
    addr = 4'(a);
    #1;
    e = mRead(a);
    chk(int'(rdData) == e, req, int'(rdData), e);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int hi;
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    for (int a = 0; a < 9; a++) rd(a, "R1");
    chk(pwmOut == 2'b00, "R1", int'(pwmOut), 0);

    // R8 readback of all fields
    wr(1, 1); wr(3, 9); wr(5, 3);
    for (int a = 0; a < 9; a++) rd(a, "R8");

    // R2 R3 R4 R5 basic waveform on ch0
    curReq = "R2_R3_R4_R5";
    wr(0, 1);
    for (int i = 0; i < 20; i++) begin idle(3); rd(7, "R2"); end
    idle(40);

    // R7 period/duty change while running, readback first
    curReq = "R7";
    wr(3, 5); rd(3, "R8");
    wr(5, 2); rd(5, "R8");
    idle(60);
    rd(7, "R3");

    // R9 counter write ignored while running
    wr(7, 200); rd(7, "R9");
    wr(8, 100); rd(8, "R9");

    // R6 full duty
    curReq = "R6";
    wr(5, 20);
    idle(40);
    hi = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); #1; if (pwmOut[0]) hi++; end
    chk(hi == 30, "R6", hi, 30);
    // R6 zero duty
    wr(5, 0);
    idle(40);
    hi = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); #1; if (pwmOut[0]) hi++; end
    chk(hi == 0, "R6", hi, 0);

    // R12 stop holds counter and pin
    curReq = "R12";
    wr(5, 3);
    idle(30);
    wr(0, 0);
    rd(7, "R12");
    idle(15);
    rd(7, "R12");

    // R10 R11 R13 preset above period on ch1 with inverted polarity
    curReq = "R10_R11_R13";
    wr(2, 0); wr(4, 4); wr(6, 2);
    wr(8, 250); rd(8, "R9");
    wr(7, 0); rd(7, "R9");
    wr(0, 8 | 3);
    for (int i = 0; i < 10; i++) begin idle(1); rd(8, "R10"); end
    idle(60);
    rd(8, "R10");

    // R12 restart after stop with prescaler from zero
    curReq = "R12";
    wr(0, 8 | 1);
    idle(7);
    wr(0, 8 | 3);
    idle(30);
    rd(8, "R12");
    rd(7, "R2");

    // R13 polarity flip while running
    curReq = "R13";
    wr(0, 4 | 3);
    idle(30);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule